// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Polarity and Output Enable

This block generates four independent pulse-width modulated waveforms from one input clock. Software programs each channel over a simple 32-bit register bus with a byte address, a write strobe, write data and combinational read data. Each channel has a cycle-length count and an active-time count, both in input-clock cycles. A per-channel polarity bit selects whether the active phase is driven high or low, and it also sets the level the pin rests at while the channel is stopped.

Each channel also has a run bit. When the run bit goes from 0 to 1, the channel copies the programmed counts into private working copies and starts a fresh cycle. Counts written while the channel runs are held back until the next stop-then-run sequence, so a running waveform never shows a half-updated setting. A separate enable register drives one output-enable pin per channel, for the pad logic outside this block.

Top module: `quad_pwm`

## Requirements
- R1: After reset every register reads 0, every `pwm_o` bit is 0 and every `pwm_oe` bit is 0.
- R2: Channel n's active-time register is at byte address n*8 and its cycle-length register at n*8+4. Both are 32 bits wide and read back the last value written. Polarity is at 0x40, run at 0x44 and output enable at 0xD0. In each of these three, bit n belongs to channel n, and bits above the channel count read 0. Any other address reads 0.
- R3: A run bit set at write edge W loads the counts at edge W+1. From W+1 on, the output is active for the first H cycles of every P-cycle period, where H is the active time and P the cycle length.
- R4: Starting one clock after a channel's run bit has been cleared, and for as long as it stays clear, the output equals the polarity bit (0 = low, 1 = high).
- R5: With the polarity bit at 0 the active level is high. With the polarity bit at 1 the active level is low.
- R6: Counts written while a channel runs leave its waveform unchanged until the run bit is cleared and set again.
- R7: A running channel whose loaded cycle length and active time are both 0 holds its output high, whatever its polarity.
- R8: If the active time is greater than or equal to a nonzero cycle length, the output stays active. If the active time is 0 and the cycle length is nonzero, the output stays inactive.
- R9: `pwm_oe[n]` equals bit n of the enable register, from the clock edge that writes it.
- R10: A restart (clear, then set) begins a new cycle at count zero. The active phase begins on the clock after the load, whatever the phase was before the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_o | output | 4 | Waveform output, one bit per channel |
| pwm_oe | output | 4 | Output-enable pin, one bit per channel |

## Verification
A working copy of the counts that is loaded at the wrong moment shows up on `pwm_o` within one period of the waveform. Either the duty pattern changes in the middle of a run, or the old pattern survives a restart. A counter that fails to wrap or to restart at zero shifts the position of the active phase relative to the start edge, and this is visible in the first cycle after the load. A wrong run-bit history shows as an output that fails to reach the polarity level one clock after a stop. A wrong enable register shows on `pwm_oe` at the edge that writes it.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  localparam int unsigned PWM_DATA_W = 32;
  localparam int unsigned PWM_ADDR_W = 8;
  localparam logic [PWM_ADDR_W-1:0] OFS_POLARITY = 8'h40;
  localparam logic [PWM_ADDR_W-1:0] OFS_RUN      = 8'h44;
  localparam logic [PWM_ADDR_W-1:0] OFS_OUT_EN   = 8'hD0;
endpackage

// File: rtl/quad_pwm_regs.sv
module quad_pwm_regs
  import quad_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = PWM_DATA_W,
  parameter int unsigned ADDR_W = PWM_ADDR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic                           reg_we,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  output logic [NUM_CH-1:0][DATA_W-1:0]  act_cfg,
  output logic [NUM_CH-1:0][DATA_W-1:0]  len_cfg,
  output logic [NUM_CH-1:0]              pol_q,
  output logic [NUM_CH-1:0]              run_q,
  output logic [NUM_CH-1:0]              oe_q
);
  localparam int unsigned SLOT_W = ADDR_W - 3;

  logic [NUM_CH-1:0][DATA_W-1:0] act_d, len_d;
  logic [NUM_CH-1:0]             pol_d, run_d, oe_d;
  logic [NUM_CH-1:0]             sel_act, sel_len;

  // Per-channel decode: slot index in the upper bits, 0 or 4 in the low bits
  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    assign sel_act[n] = (reg_addr[ADDR_W-1:3] == SLOT_W'(n)) && (reg_addr[2:0] == 3'd0);
    assign sel_len[n] = (reg_addr[ADDR_W-1:3] == SLOT_W'(n)) && (reg_addr[2:0] == 3'd4);
  end

  always_comb begin
    act_d = act_cfg;
    len_d = len_cfg;
    pol_d = pol_q;
    run_d = run_q;
    oe_d  = oe_q;
    if (reg_we) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (sel_act[n]) act_d[n] = reg_wdata;
        if (sel_len[n]) len_d[n] = reg_wdata;
      end
      if (reg_addr == OFS_POLARITY) pol_d = reg_wdata[NUM_CH-1:0];
      if (reg_addr == OFS_RUN)      run_d = reg_wdata[NUM_CH-1:0];
      if (reg_addr == OFS_OUT_EN)   oe_d  = reg_wdata[NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cfg <= '0;
      len_cfg <= '0;
      pol_q   <= '0;
      run_q   <= '0;
      oe_q    <= '0;
    end else begin
      act_cfg <= act_d;
      len_cfg <= len_d;
      pol_q   <= pol_d;
      run_q   <= run_d;
      oe_q    <= oe_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (sel_act[n]) reg_rdata = act_cfg[n];
      if (sel_len[n]) reg_rdata = len_cfg[n];
    end
    if (reg_addr == OFS_POLARITY) reg_rdata = DATA_W'(pol_q);
    if (reg_addr == OFS_RUN)      reg_rdata = DATA_W'(run_q);
    if (reg_addr == OFS_OUT_EN)   reg_rdata = DATA_W'(oe_q);
  end

  // R9: the enable register captures the written bits at the write edge
  a_r9_oe_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_OUT_EN) |=> (oe_q == $past(reg_wdata[NUM_CH-1:0])));
endmodule

// File: rtl/quad_pwm_chan.sv
module quad_pwm_chan #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pol,
  input  logic [DATA_W-1:0] act_cfg,
  input  logic [DATA_W-1:0] len_cfg,
  output logic              wave_o
);
  logic              live_q, live_d;
  logic [DATA_W-1:0] act_q, act_d;
  logic [DATA_W-1:0] len_q, len_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W:0]   cnt_inc;
  logic              load_en, step_en, both_zero, in_active;

  assign load_en = run && !live_q;
  assign step_en = run && live_q;
  assign cnt_inc = {1'b0, cnt_q} + {{DATA_W{1'b0}}, 1'b1};

  always_comb begin
    live_d = run;
    act_d  = act_q;
    len_d  = len_q;
    cnt_d  = cnt_q;
    if (load_en) begin
      act_d = act_cfg;
      len_d = len_cfg;
      cnt_d = '0;
    end else if (step_en) begin
      cnt_d = (cnt_inc >= {1'b0, len_q}) ? '0 : cnt_inc[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      act_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else begin
      live_q <= live_d;
      act_q  <= act_d;
      len_q  <= len_d;
      cnt_q  <= cnt_d;
    end
  end

  assign both_zero = (len_q == '0) && (act_q == '0);
  assign in_active = (cnt_q < act_q);
  assign wave_o    = !live_q ? pol : (both_zero ? 1'b1 : (in_active ^ pol));

  // R6: working counts never move while the channel keeps running
  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && live_q) |=> ($stable(act_q) && $stable(len_q)));
  // R10: a run rising edge restarts the cycle at zero
  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !live_q) |=> (cnt_q == '0));
  // R3: the counter stays inside the loaded cycle length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && len_q != '0) |-> (cnt_q < len_q));
  // R4: a run bit that has been clear for a clock leaves the pin at the polarity level
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> (wave_o == pol));
endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import quad_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = PWM_DATA_W,
  parameter int unsigned ADDR_W = PWM_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] pwm_oe
);
  logic [NUM_CH-1:0][DATA_W-1:0] act_cfg, len_cfg;
  logic [NUM_CH-1:0]             pol_q, run_q, oe_q;

  quad_pwm_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .act_cfg   (act_cfg),
    .len_cfg   (len_cfg),
    .pol_q     (pol_q),
    .run_q     (run_q),
    .oe_q      (oe_q)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    quad_pwm_chan #(.DATA_W(DATA_W)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q[n]),
      .pol     (pol_q[n]),
      .act_cfg (act_cfg[n]),
      .len_cfg (len_cfg[n]),
      .wave_o  (pwm_o[n])
    );
  end

  assign pwm_oe = oe_q;

  // R1: leaving reset, every pin is low
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_o == '0 && pwm_oe == '0));
endmodule

// File: tb/quad_pwm_tb_top.sv
module quad_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_o;
  logic [3:0]  pwm_oe;

  int checks = 0;
  int fails  = 0;
  logic [3:0] run_v = '0;
  logic [3:0] pol_v = '0;

  always #2 clk = ~clk;

  quad_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  function automatic logic level(input int k, input int len, input int act, input logic pol);
    logic a;
    if (len == 0 && act == 0) return 1'b1;
    if (len == 0) a = (act != 0);
    else          a = ((k % len) < act);
    return a ^ pol;
  endfunction

  // Samples the channel at the negedges from index k0 on; index 0 is the first clock after the load
  task automatic wave_chk(input int ch, input int len, input int act, input logic pol,
                          input int k0, input int n, input string req);
    for (int k = k0; k < k0 + n; k++) begin
      @(negedge clk);
      chk(pwm_o[ch] == level(k, len, act, pol), req, 32'(pwm_o[ch]), 32'(level(k, len, act, pol)));
    end
  endtask

  task automatic restart(input int ch);
    run_v[ch] = 1'b0; wr(8'h44, 32'(run_v));
    run_v[ch] = 1'b1; wr(8'h44, 32'(run_v));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(pwm_o == 4'h0, "R1 pwm after reset", 32'(pwm_o), 0);
    chk(pwm_oe == 4'h0, "R1 oe after reset", 32'(pwm_oe), 0);
    rd_chk(8'h04, 0, "R1 len0 reset");
    rd_chk(8'h18, 0, "R1 act3 reset");
    rd_chk(8'h44, 0, "R1 run reset");
  endtask

  task automatic t_regs;
    for (int n = 0; n < 4; n++) begin
      wr(8'(n * 8),     32'hA000_0000 + 32'(n));
      wr(8'(n * 8 + 4), 32'h0B00_0010 + 32'(n));
    end
    for (int n = 0; n < 4; n++) begin
      rd_chk(8'(n * 8),     32'hA000_0000 + 32'(n), "R2 act readback");
      rd_chk(8'(n * 8 + 4), 32'h0B00_0010 + 32'(n), "R2 len readback");
    end
    wr(8'hD0, 32'hFFFF_FFF0);
    rd_chk(8'hD0, 32'h0, "R2 upper bits read zero");
    rd_chk(8'h20, 32'h0, "R2 unmapped reads zero");
    rd_chk(8'h48, 32'h0, "R2 unmapped reads zero");
    chk(pwm_o == 4'h0, "R4 idle normal polarity low", 32'(pwm_o), 0);
  endtask

  task automatic t_oe;
    wr(8'hD0, 32'hA);
    chk(pwm_oe == 4'hA, "R9 oe follows", 32'(pwm_oe), 32'hA);
    wr(8'hD0, 32'h5);
    chk(pwm_oe == 4'h5, "R9 oe follows", 32'(pwm_oe), 32'h5);
    rd_chk(8'hD0, 32'h5, "R2 oe readback");
  endtask

  task automatic t_wave;
    wr(8'h00, 2); wr(8'h04, 5);
    run_v[0] = 1'b1; wr(8'h44, 32'(run_v));
    chk(pwm_o[0] == 1'b0, "R3 idle until load edge", 32'(pwm_o[0]), 0);
    wave_chk(0, 5, 2, 1'b0, 0, 12, "R3 duty 2/5 normal");
    chk(pwm_o[3:1] == 3'b000, "R4 other channels idle", 32'(pwm_o[3:1]), 0);
  endtask

  task automatic t_shadow;
    restart(0);
    wr(8'h00, 3);   // k=0,1 pass
    wr(8'h04, 3);   // k=2,3 pass
    wave_chk(0, 5, 2, 1'b0, 4, 10, "R6 running waveform unchanged");
    restart(0);
    wave_chk(0, 3, 3, 1'b0, 0, 6, "R8 act>=len stays active");
    wr(8'h00, 0); wr(8'h04, 4);
    restart(0);
    wave_chk(0, 4, 0, 1'b0, 0, 6, "R8 act=0 stays inactive");
    wr(8'h00, 1); wr(8'h04, 3);
    restart(0);
    wave_chk(0, 3, 1, 1'b0, 0, 1, "R10 restart begins active");
    wave_chk(0, 3, 1, 1'b0, 1, 5, "R10 restart phase from zero");
  endtask

  task automatic t_stop;
    run_v[0] = 1'b0; wr(8'h44, 32'(run_v));
    @(negedge clk);
    chk(pwm_o[0] == 1'b0, "R4 stopped normal low", 32'(pwm_o[0]), 0);
    wave_chk(0, 0, 0, 1'b1, 0, 0, "R4");
  endtask

  task automatic t_polarity;
    pol_v[2] = 1'b1; wr(8'h40, 32'(pol_v));
    @(negedge clk);
    chk(pwm_o[2] == 1'b1, "R4 stopped inverted high", 32'(pwm_o[2]), 1);
    wr(8'h10, 1); wr(8'h14, 6);
    run_v[2] = 1'b1; wr(8'h44, 32'(run_v));
    wave_chk(2, 6, 1, 1'b1, 0, 12, "R5 inverted active low");
    run_v[2] = 1'b0; wr(8'h44, 32'(run_v));
    @(negedge clk);
    chk(pwm_o[2] == 1'b1, "R4 inverted idle after stop", 32'(pwm_o[2]), 1);
  endtask

  task automatic t_zero;
    wr(8'h18, 0); wr(8'h1C, 0);
    run_v[3] = 1'b1; wr(8'h44, 32'(run_v));
    wave_chk(3, 0, 0, 1'b0, 0, 4, "R7 zero counts high normal");
    pol_v[3] = 1'b1; wr(8'h40, 32'(pol_v));
    wave_chk(3, 0, 0, 1'b1, 0, 4, "R7 zero counts high inverted");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_oe();
    t_wave();
    t_shadow();
    t_stop();
    t_polarity();
    t_zero();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule